// File: doc/BRIEF.md
# Event timer global control

This block is the shared part of a three-channel event timer. It holds a read-only capability word, a two-bit global configuration register and a 64-bit free-running up-counter. It also steers the expiry pulses of the comparator channels onto a bank of 24 interrupt lines. Software reaches it through a 32-bit register port. Writes are strobed, and read data follows the address combinationally.

Setting the global enable bit starts the counter from the value it last held. The same write sends a one-cycle arm pulse to every channel whose comparator is not all ones. Clearing the bit freezes the counter and sends a one-cycle disarm pulse to all channels. A legacy routing bit overrides the route fields of channels 0 and 1, and it raises an output that tells the older interval timer to stand down.

Top module: `evt_timer_glob`

## Requirements
- R1: A read of byte offset 0x00 returns 0x8086A201, and a read of offset 0x04 returns the tick period parameter in femtoseconds (default 10,000,000).
- R2: A read of offset 0x10 returns the enable bit in bit 0, the legacy bit in bit 1 and zero in all other bits. A write to 0x10 changes only those two bits. Offset 0x14 always reads zero.
- R3: While enable is set, the counter advances by one on every clock that carries no counter write. While enable is clear, the counter holds its value.
- R4: A read of offset 0xF0 returns bits 31:0 of the counter, and a read of offset 0xF4 returns bits 63:32. While enabled, each read returns the live count.
- R5: A write to 0xF0 or 0xF4 replaces only that 32-bit half, and the other half is kept. A counter write made while enable is set is still accepted, and `cnt_wr_warn_o` pulses high for one cycle after it.
- R6: A configuration write that changes enable from 0 to 1 drives `arm_o` for the following cycle only. Bit c of `arm_o` is set exactly when `ch_cmp_ones_i[c]` was low at the write.
- R7: A configuration write that changes enable from 1 to 0 drives `disarm_o` to all ones for the following cycle only.
- R8: In the cycle after a clock on which channel c has `ch_fire_i[c]`, `ch_en_i[c]` and global enable all high, `irq_o` has a one-cycle pulse on the line given by route field c (`ch_route_i[5c+4:5c]`). Route values 24 to 31 drive no line. Pulses from channels on the same line are ORed, and no line pulses while global enable is clear.
- R9: While the legacy bit is set, channel 0 pulses line 0 and channel 1 pulses line 8 whatever their route fields hold. Channel 2 still uses its own route field.
- R10: `legacy_dis_o` goes high on the write that sets the legacy bit and low on the write that clears it. It is low after every reset.
- R11: Writes to offsets 0x00, 0x04, 0x14 and 0x20 change nothing. Offset 0x20 and every unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| ch_fire_i | input | 3 | Expiry pulse from each channel |
| ch_en_i | input | 3 | Interrupt enable bit of each channel |
| ch_route_i | input | 15 | Five-bit route field of each channel, channel 0 lowest |
| ch_cmp_ones_i | input | 3 | High when a channel's comparator holds all ones |
| arm_o | output | 3 | One-cycle arm pulse per channel |
| disarm_o | output | 3 | One-cycle disarm pulse per channel |
| irq_o | output | 24 | Interrupt line pulses |
| legacy_dis_o | output | 1 | Tells the older interval timer to stand down |
| cnt_wr_warn_o | output | 1 | Pulse after a counter write made while enabled |
| count_o | output | 64 | Current counter value for the channels |

## Verification
The assertions assume one register access per clock, so a configuration write and a counter write never coincide. They also assume that `ch_cmp_ones_i` is a plain level that is valid on the clock of the enable write. The counter properties look at the write strobe and the address together, so they are only sound when a counter write is the only event that can break the count-by-one rule. The stimulus drives every input once per cycle on the falling edge and uses a single address port, so it meets both assumptions. Random configuration words toggle enable and legacy freely, and random route values reach past line 23.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] OFF_CAP_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CFG_LO = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CFG_HI = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'hF0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'hF4;

  localparam logic [DATA_W-1:0] CAP_ID = 32'h8086_A201;

  localparam int unsigned LEG_LINE_CH0 = 0;
  localparam int unsigned LEG_LINE_CH1 = 8;

  typedef struct packed {
    logic leg;
    logic en;
  } glob_cfg_t;
endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
  import evt_timer_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [1:0]     wdata_i,
  input  logic [NCH-1:0] cmp_ones_i,
  output glob_cfg_t      cfg_o,
  output logic [NCH-1:0] arm_o,
  output logic [NCH-1:0] disarm_o
);
  glob_cfg_t      cfg_q;
  logic [NCH-1:0] arm_q, disarm_q;
  logic           en_rise, en_fall;

  assign en_rise = wr_i &  wdata_i[0] & ~cfg_q.en;
  assign en_fall = wr_i & ~wdata_i[0] &  cfg_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      arm_q    <= '0;
      disarm_q <= '0;
    end else begin
      if (wr_i) begin
        cfg_q.en  <= wdata_i[0];
        cfg_q.leg <= wdata_i[1];
      end
      // skip channels whose comparator was never loaded
      arm_q    <= en_rise ? ~cmp_ones_i : '0;
      disarm_q <= en_fall ? '1 : '0;
    end
  end

  assign cfg_o    = cfg_q;
  assign arm_o    = arm_q;
  assign disarm_o = disarm_q;
endmodule

// File: rtl/evt_main_cnt.sv
module evt_main_cnt
  import evt_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              warn_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             warn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      if (wr_lo_i)      cnt_q[DATA_W-1:0]     <= wdata_i;
      else if (wr_hi_i) cnt_q[CNT_W-1:DATA_W] <= wdata_i;
      else if (en_i)    cnt_q                 <= cnt_q + 1'b1;
      warn_q <= (wr_lo_i | wr_hi_i) & en_i;
    end
  end

  assign count_o = cnt_q;
  assign warn_o  = warn_q;
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
  import evt_timer_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned NLINES = 24,
  parameter int unsigned RTE_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               leg_i,
  input  logic [NCH-1:0]     fire_i,
  input  logic [NCH-1:0]     ch_en_i,
  input  logic [NCH*RTE_W-1:0] route_i,
  output logic [NLINES-1:0]  irq_o
);
  logic [RTE_W-1:0]  dest [NCH];
  logic [NLINES-1:0] irq_d, irq_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == 0) begin : g_leg0
      assign dest[c] = leg_i ? RTE_W'(LEG_LINE_CH0) : route_i[c*RTE_W +: RTE_W];
    end else if (c == 1) begin : g_leg1
      assign dest[c] = leg_i ? RTE_W'(LEG_LINE_CH1) : route_i[c*RTE_W +: RTE_W];
    end else begin : g_plain
      assign dest[c] = route_i[c*RTE_W +: RTE_W];
    end
  end

  always_comb begin
    irq_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (fire_i[c] && ch_en_i[c] && en_i && (int'(dest[c]) < NLINES))
        irq_d[dest[c]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_timer_glob.sv
module evt_timer_glob
  import evt_timer_pkg::*;
#(
  parameter int unsigned NCH     = 3,
  parameter int unsigned NLINES  = 24,
  parameter int unsigned RTE_W   = $clog2(NLINES),
  parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [NCH-1:0]       ch_fire_i,
  input  logic [NCH-1:0]       ch_en_i,
  input  logic [NCH*RTE_W-1:0] ch_route_i,
  input  logic [NCH-1:0]       ch_cmp_ones_i,
  output logic [NCH-1:0]       arm_o,
  output logic [NCH-1:0]       disarm_o,
  output logic [NLINES-1:0]    irq_o,
  output logic                 legacy_dis_o,
  output logic                 cnt_wr_warn_o,
  output logic [CNT_W-1:0]     count_o
);
  glob_cfg_t        cfg;
  logic             glob_en;
  logic             cfg_wr, cnt_wr_lo, cnt_wr_hi;
  logic [CNT_W-1:0] cnt;

  assign cfg_wr    = reg_wr_i && (reg_addr_i == OFF_CFG_LO);
  assign cnt_wr_lo = reg_wr_i && (reg_addr_i == OFF_CNT_LO);
  assign cnt_wr_hi = reg_wr_i && (reg_addr_i == OFF_CNT_HI);

  evt_cfg_reg #(.NCH(NCH)) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr),
    .wdata_i    (reg_wdata_i[1:0]),
    .cmp_ones_i (ch_cmp_ones_i),
    .cfg_o      (cfg),
    .arm_o      (arm_o),
    .disarm_o   (disarm_o)
  );

  assign glob_en = cfg.en;

  evt_main_cnt cnt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (glob_en),
    .wr_lo_i (cnt_wr_lo),
    .wr_hi_i (cnt_wr_hi),
    .wdata_i (reg_wdata_i),
    .count_o (cnt),
    .warn_o  (cnt_wr_warn_o)
  );

  evt_irq_route #(.NCH(NCH), .NLINES(NLINES), .RTE_W(RTE_W)) route_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (glob_en),
    .leg_i   (cfg.leg),
    .fire_i  (ch_fire_i),
    .ch_en_i (ch_en_i),
    .route_i (ch_route_i),
    .irq_o   (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFF_CAP_LO: reg_rdata_o = CAP_ID;
      OFF_CAP_HI: reg_rdata_o = TICK_FS;
      OFF_CFG_LO: reg_rdata_o = {{(DATA_W-2){1'b0}}, cfg.leg, cfg.en};
      OFF_CNT_LO: reg_rdata_o = cnt[DATA_W-1:0];
      OFF_CNT_HI: reg_rdata_o = cnt[CNT_W-1:DATA_W];
      default:    reg_rdata_o = '0;
    endcase
  end

  assign legacy_dis_o = cfg.leg;
  assign count_o      = cnt;
endmodule

// File: rtl/evt_timer_glob_chk.sv
module evt_timer_glob_chk
  import evt_timer_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned NLINES = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              glob_en,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [NCH-1:0]    ch_cmp_ones_i,
  input logic [NCH-1:0]    arm_o,
  input logic [NCH-1:0]    disarm_o,
  input logic [NLINES-1:0] irq_o
);
  logic cnt_wr;
  assign cnt_wr = reg_wr_i && (reg_addr_i == OFF_CNT_LO || reg_addr_i == OFF_CNT_HI);

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(glob_en) && !$past(cnt_wr)) |-> count_o == $past(count_o) + 1'b1);

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(glob_en) && !$past(cnt_wr)) |-> $stable(count_o));

  // R6
  arm_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(glob_en) |-> arm_o == ~$past(ch_cmp_ones_i));

  // R7
  disarm_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(glob_en) |-> &disarm_o);

  // R7
  arm_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|arm_o) && (|disarm_o)));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(glob_en));
endmodule

bind evt_timer_glob evt_timer_glob_chk #(.NCH(NCH), .NLINES(NLINES)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .glob_en       (glob_en),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .count_o       (count_o),
  .ch_cmp_ones_i (ch_cmp_ones_i),
  .arm_o         (arm_o),
  .disarm_o      (disarm_o),
  .irq_o         (irq_o)
);

// File: tb/evt_timer_glob_tb_top.sv
module evt_timer_glob_tb_top;
  import evt_timer_pkg::*;
  localparam int NCH = 3, NLINES = 24, RTE_W = 5;
  localparam logic [31:0] TICK = 32'd10_000_000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, rdata;
  logic [NCH-1:0] fire = '0, chen = '0, ones = '0, arm, disarm;
  logic [NCH*RTE_W-1:0] route = '0;
  logic [NLINES-1:0] irq;
  logic leg_dis, warn;
  logic [63:0] count;

  evt_timer_glob #(.NCH(NCH), .NLINES(NLINES), .TICK_FS(TICK)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .ch_fire_i(fire), .ch_en_i(chen),
    .ch_route_i(route), .ch_cmp_ones_i(ones), .arm_o(arm), .disarm_o(disarm),
    .irq_o(irq), .legacy_dis_o(leg_dis), .cnt_wr_warn_o(warn), .count_o(count));

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic m_en, m_leg, m_warn, m_cntwr;
  logic [63:0] m_cnt;
  logic [NCH-1:0] m_arm, m_disarm;
  logic [NLINES-1:0] m_irq;

  function automatic logic [NLINES-1:0] exp_irq(logic [NCH-1:0] f, logic [NCH-1:0] e,
      logic [NCH*RTE_W-1:0] r, logic en, logic leg);
    logic [NLINES-1:0] v = '0;
    for (int c = 0; c < NCH; c++) begin
      int d = int'(r[c*RTE_W +: RTE_W]);
      if (leg && c == 0) d = 0;
      if (leg && c == 1) d = 8;
      if (f[c] && e[c] && en && d < NLINES) v[d] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return 32'h8086_A201;
      8'h04: return TICK;
      8'h10: return {30'b0, m_leg, m_en};
      8'hF0: return m_cnt[31:0];
      8'hF4: return m_cnt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R1";
      8'h10, 8'h14: return "R2";
      8'hF0, 8'hF4: return "R4";
      default: return "R11";
    endcase
  endfunction

  // reference model, built from the requirements
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_leg = 0; m_cnt = '0; m_arm = '0; m_disarm = '0;
      m_irq = '0; m_warn = 0; m_cntwr = 0;
    end else begin
      logic old_en;
      old_en   = m_en;
      m_irq    = exp_irq(fire, chen, route, m_en, m_leg);
      m_cntwr  = reg_wr && (reg_addr == 8'hF0 || reg_addr == 8'hF4);
      m_warn   = m_cntwr && m_en;
      m_arm    = '0;
      m_disarm = '0;
      if (reg_wr && reg_addr == 8'h10) begin
        if (reg_wdata[0] && !m_en) m_arm = ~ones;
        if (!reg_wdata[0] && m_en) m_disarm = '1;
        m_en  = reg_wdata[0];
        m_leg = reg_wdata[1];
      end
      if (reg_wr && reg_addr == 8'hF0)      m_cnt[31:0]  = reg_wdata;
      else if (reg_wr && reg_addr == 8'hF4) m_cnt[63:32] = reg_wdata;
      else if (old_en)                      m_cnt        = m_cnt + 1;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    chk(irq === m_irq, m_leg ? "R9" : "R8", 64'(irq), 64'(m_irq));
    chk(arm === m_arm, "R6", 64'(arm), 64'(m_arm));
    chk(disarm === m_disarm, "R7", 64'(disarm), 64'(m_disarm));
    chk(warn === m_warn, "R5", 64'(warn), 64'(m_warn));
    chk(leg_dis === m_leg, "R10", 64'(leg_dis), 64'(m_leg));
    chk(count === m_cnt, m_cntwr ? "R5" : "R3", count, m_cnt);
  endtask

  // drives one cycle from the falling edge, checks read data, then outputs
  task automatic cyc(bit wr, logic [7:0] a, logic [31:0] d, logic [NCH-1:0] f,
      logic [NCH-1:0] e, logic [NCH*RTE_W-1:0] r, logic [NCH-1:0] o);
    reg_wr = wr; reg_addr = a; reg_wdata = d; fire = f; chen = e; route = r; ones = o;
    #1;
    chk(rdata === exp_read(a), read_tag(a), 64'(rdata), 64'(exp_read(a)));
    @(negedge clk_i);
    check_outs();
  endtask

  task automatic idle(logic [7:0] a);
    cyc(0, a, '0, '0, '0, route, '0);
  endtask

  function automatic logic [14:0] rts(int r0, int r1, int r2);
    return {5'(r2), 5'(r1), 5'(r0)};
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // reset state: R10 legacy output low, counter and pulses cleared
    chk(count === '0 && irq === '0 && arm === '0 && disarm === '0, "R3", count, 0);
    chk(leg_dis === 1'b0 && warn === 1'b0, "R10", 64'(leg_dis), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R11 reads, then ignored writes
    foreach (rdlist[i]) idle(rdlist[i]);
    cyc(1, 8'h00, 32'hFFFF_FFFF, '0, '0, '0, '0);
    cyc(1, 8'h04, 32'h1234_5678, '0, '0, '0, '0);
    cyc(1, 8'h14, 32'hFFFF_FFFF, '0, '0, '0, '0);
    cyc(1, 8'h20, 32'hFFFF_FFFF, '0, '0, '0, '0);
    foreach (rdlist[i]) idle(rdlist[i]);

    // R5 counter halves while disabled, R3 hold
    cyc(1, 8'hF0, 32'hFFFF_FFF0, '0, '0, '0, '0);
    cyc(1, 8'hF4, 32'h0000_0001, '0, '0, '0, '0);
    repeat (3) idle(8'hF0);
    // R8 no pulse while globally disabled
    cyc(0, 8'hF0, '0, 3'b111, 3'b111, rts(3, 4, 5), '0);
    // R6 enable with junk upper bits, channel 1 comparator all ones
    cyc(1, 8'h10, 32'hFFFF_FFFD, '0, '0, '0, 3'b010);
    idle(8'h10);
    // R4 carry across the 32-bit boundary
    repeat (20) idle(8'hF0);
    idle(8'hF4);
    // R8 two channels onto one line, one on line 23, one out of range
    cyc(0, 8'hF4, '0, 3'b111, 3'b111, rts(3, 3, 23), '0);
    cyc(0, 8'hF4, '0, 3'b111, 3'b101, rts(30, 3, 7), '0);
    idle(8'hF4);
    // R9 legacy forcing, R10 output
    cyc(1, 8'h10, 32'h0000_0003, '0, '0, '0, '0);
    cyc(0, 8'h10, '0, 3'b111, 3'b111, rts(17, 20, 2), '0);
    idle(8'h10);
    // R5 counter write while enabled
    cyc(1, 8'hF0, 32'h0000_0100, '0, '0, '0, '0);
    idle(8'hF0);
    // R7 disable, R10 clear legacy
    cyc(1, 8'h10, 32'h0000_0000, '0, '0, '0, '0);
    repeat (2) idle(8'hF0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      logic [7:0] a = rdlist[$urandom % 10];
      logic [31:0] d = $urandom;
      logic [14:0] rt = 15'($urandom);
      if (r < 8)       cyc(1, 8'h10, d, 3'($urandom), 3'($urandom), rt, 3'($urandom));
      else if (r < 12) cyc(1, ($urandom % 2) ? 8'hF0 : 8'hF4, d, '0, '0, rt, '0);
      else if (r < 15) cyc(1, ignlist[$urandom % 4], d, 3'($urandom), 3'($urandom), rt, '0);
      else             cyc(0, a, d, 3'($urandom), 3'($urandom), rt, 3'($urandom));
    end
    finish_run();
  end

  logic [7:0] rdlist [10] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h20, 8'hF0, 8'hF4, 8'h08, 8'h30, 8'hFC};
  logic [7:0] ignlist [4] = '{8'h00, 8'h04, 8'h14, 8'h20};
endmodule